// File: doc/BRIEF.md
# Pipelined Eight-Point Lifting DCT

This block computes a one-dimensional forward eight-point discrete cosine transform approximation on a fully pipelined datapath. It accepts one vector of eight signed integer samples per clock, marked by a valid strobe. A fixed number of cycles later it returns eight subband coefficients, all aligned to the same cycle. The structure follows a fast butterfly factorization. Every plane rotation in that factorization is replaced by lifting steps (multiply by a constant, then add). Because of this, each constant multiplier can be rounded to finite precision and the transform stays exactly invertible.

Each constant is an integer divided by 2^CWL. It is built as a shift-and-add network over the canonic signed-digit form of the integer, followed by an arithmetic right shift with two's-complement truncation. Every adder and every multiplier ends in a register. Shorter paths are padded with delay registers so that all lanes leave together. The constants and the number of low bits dropped at the odd-part butterfly nodes are elaboration parameters. Node widths carry a fixed sign/MSB position sized for inputs of magnitude at most 255.

Top module: `lift_dct8`

## Requirements
- R1: With x = input lanes 0..7 and mq(v,c) = floor(v*c/256), the outputs are computed as follows.
  - First stage: a_k = x_k + x_(7-k) and b_k = x_k - x_(7-k), for k = 0..3.
  - Even part, with c0 = a0+a3, c1 = a1+a2, c2 = a1-a2, c3 = a0-a3:
    - out0 = c0+c1
    - out4 = c0-c1
    - out2 = v = c3+mq(c2,P1)
    - out6 = c2+mq(v,U1)
  - Odd part, with m2 = b2+mq(b1,P2), m1 = b1+mq(m2,U2), n = m2+mq(m1,P3), f0 = b0+n, f1 = b0-n, f2 = b3-m1, f3 = b3+m1:
    - out1 = g = f0+mq(f3,P4)
    - out5 = f1+mq(f2,P5)
    - out7 = f3+mq(g,U3)
    - out3 = f2
  - Defaults: P1 = -171, U1 = 237, P2 = -106, U2 = 181, P3 = -106, P4 = -25, U3 = 50, P5 = -78, and CWL = 8.
- R2: out_valid rises exactly 12 cycles after a cycle with in_valid high and is low in every other cycle after reset. All eight lanes of that vector appear in that same cycle.
- R3: Every internal node is IN_W+GROW bits wide (13 by default). For input magnitudes up to 255, no adder or multiplier result leaves that range.
- R4: Each constant multiplier returns floor(v*C/2^CWL) of its registered input, one cycle after that input.
- R5: Lane 0 is exactly the sum of all eight inputs. Lane 4 is exactly (x0+x3+x4+x7)-(x1+x2+x5+x6). No multiplier lies on either path.
- R6: With ODD_DROP = d, the four odd butterfly nodes f0..f3 have their d low bits cleared (floor to a multiple of 2^d) while the MSB position is unchanged. Lane 3 then has its d low bits zero, and all lanes follow the R1 flow with that truncation.
- R7: At default parameters each lane stays within 6 of a real-valued evaluation of the same flow graph that uses the same constants without truncation.
- R8: While reset is held and in the cycle after it, out_valid is 0 and every lane of out_coef is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a vector on in_samp |
| in_samp | input | 8 x IN_W | Eight signed samples, lane k in bits [k*IN_W +: IN_W] |
| out_valid | output | 1 | Marks an aligned output vector |
| out_coef | output | 8 x (IN_W+GROW) | Eight signed subband coefficients, lane k = out k of R1 |

## Verification
The embedded assertions check four things on every cycle:
- no adder or multiplier result leaves its node width;
- each multiplier output equals the exact floored product of its previous input;
- out_valid follows in_valid exactly twelve cycles later;
- truncated nodes carry zero low bits whenever a truncating variant is built.

The numeric content of the transform can only be shown by the bench scenarios. These are:
- lane values against an integer model of the flow graph, over directed full-scale, impulse and alternating patterns and random vectors with gaps;
- exact DC and lane-4 sums;
- the error bound against a real-valued evaluation;
- a second instance that drops two low bits in the odd butterflies.

// File: rtl/lift_pkg.sv
package lift_pkg;

    localparam int NLANE = 8;
    localparam int HALF  = NLANE / 2;
    localparam int LAT   = 12;

    // Canonic signed digit of value at position pos: -1, 0 or +1.
    function automatic int csd_digit(input int value, input int pos);
        int v;
        int d;
        v = value;
        d = 0;
        for (int i = 0; i <= pos; i++) begin
            if ((v & 1) != 0) d = 2 - (v & 3);
            else              d = 0;
            if (i == pos) return d;
            v = (v - d) >>> 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/lift_cmul.sv
module lift_cmul
    import lift_pkg::*;
#(
    parameter int W    = 13,
    parameter int COEF = 1,
    parameter int CWL  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int NDIG = CWL + 2;
    localparam int PW   = W + CWL + 3;
    localparam int MAXV = (2 ** (W - 1)) - 1;
    localparam int MINV = -(2 ** (W - 1));

    logic signed [PW-1:0] dext;
    logic signed [PW-1:0] term [NDIG];
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] prod_sh;

    assign dext = PW'(din);

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        localparam int DIG = csd_digit(COEF, i);
        if (DIG > 0) begin : g_pos
            assign term[i] = dext <<< i;
        end else if (DIG < 0) begin : g_neg
            assign term[i] = -(dext <<< i);
        end else begin : g_zero
            assign term[i] = '0;
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NDIG; i++) acc = acc + term[i];
    end

    assign prod_sh = acc >>> CWL;

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= prod_sh[W-1:0];
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(prod_sh) >= MINV) && (int'(prod_sh) <= MAXV));

    assert_mul_exact_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(dout) == ((int'($past(din)) * COEF) >>> CWL)));

endmodule

// File: rtl/lift_addreg.sv
module lift_addreg #(
    parameter int W    = 13,
    parameter bit SUB  = 1'b0,
    parameter int DROP = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] dout
);
    localparam logic [W-1:0] KEEP = {W{1'b1}} << DROP;

    logic signed [W:0] sum;

    assign sum = SUB ? ((W+1)'(a) - (W+1)'(b)) : ((W+1)'(a) + (W+1)'(b));

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= sum[W-1:0] & KEEP;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        sum[W] == sum[W-1]);

endmodule

// File: rtl/lift_delay.sv
module lift_delay #(
    parameter int W = 13,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (D == 0) begin : g_wire
        assign dout = din;
    end else begin : g_regs
        logic [W-1:0] sr [D];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < D; i++) sr[i] <= '0;
            end else begin
                sr[0] <= din;
                for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
            end
        end
        assign dout = sr[D-1];
    end

endmodule

// File: rtl/lift_dct8.sv
module lift_dct8
    import lift_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter int GROW     = 4,
    parameter int CWL      = 8,
    parameter int P1       = -171,
    parameter int U1       = 237,
    parameter int P2       = -106,
    parameter int U2       = 181,
    parameter int P3       = -106,
    parameter int P4       = -25,
    parameter int U3       = 50,
    parameter int P5       = -78,
    parameter int ODD_DROP = 0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic signed [7:0][IN_W-1:0]         in_samp,
    output logic                                out_valid,
    output logic signed [7:0][IN_W+GROW-1:0]    out_coef
);
    localparam int LW = IN_W + GROW;

    logic signed [LW-1:0] xs [NLANE];
    logic signed [LW-1:0] a_s [HALF];
    logic signed [LW-1:0] b_s [HALF];

    for (genvar k = 0; k < NLANE; k++) begin : g_ext
        assign xs[k] = LW'(signed'(in_samp[k]));
    end

    // Stage 1: mirrored pair butterflies
    for (genvar k = 0; k < HALF; k++) begin : g_bfly
        lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_sum (
            .clk(clk), .rst(rst), .a(xs[k]), .b(xs[NLANE-1-k]), .dout(a_s[k]));
        lift_addreg #(.W(LW), .SUB(1'b1), .DROP(0)) u_dif (
            .clk(clk), .rst(rst), .a(xs[k]), .b(xs[NLANE-1-k]), .dout(b_s[k]));
    end

    // ---------------- even half ----------------
    logic signed [LW-1:0] c0, c1, c2, c3;
    logic signed [LW-1:0] y0, y4, pm1, c3_d, v_n, um1, c2_d, w_n;
    logic signed [LW-1:0] y0_o, y4_o, y2_o, y6_o;

    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_c0 (.clk(clk), .rst(rst), .a(a_s[0]), .b(a_s[3]), .dout(c0));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_c1 (.clk(clk), .rst(rst), .a(a_s[1]), .b(a_s[2]), .dout(c1));
    lift_addreg #(.W(LW), .SUB(1'b1), .DROP(0)) u_c2 (.clk(clk), .rst(rst), .a(a_s[1]), .b(a_s[2]), .dout(c2));
    lift_addreg #(.W(LW), .SUB(1'b1), .DROP(0)) u_c3 (.clk(clk), .rst(rst), .a(a_s[0]), .b(a_s[3]), .dout(c3));

    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_y0 (.clk(clk), .rst(rst), .a(c0), .b(c1), .dout(y0));
    lift_addreg #(.W(LW), .SUB(1'b1), .DROP(0)) u_y4 (.clk(clk), .rst(rst), .a(c0), .b(c1), .dout(y4));

    lift_cmul  #(.W(LW), .COEF(P1), .CWL(CWL)) u_pm1 (.clk(clk), .rst(rst), .din(c2), .dout(pm1));
    lift_delay #(.W(LW), .D(1)) u_c3d (.clk(clk), .rst(rst), .din(c3), .dout(c3_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_v (.clk(clk), .rst(rst), .a(c3_d), .b(pm1), .dout(v_n));

    lift_cmul  #(.W(LW), .COEF(U1), .CWL(CWL)) u_um1 (.clk(clk), .rst(rst), .din(v_n), .dout(um1));
    lift_delay #(.W(LW), .D(3)) u_c2d (.clk(clk), .rst(rst), .din(c2), .dout(c2_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_w (.clk(clk), .rst(rst), .a(c2_d), .b(um1), .dout(w_n));

    lift_delay #(.W(LW), .D(LAT-3)) u_y0o (.clk(clk), .rst(rst), .din(y0),  .dout(y0_o));
    lift_delay #(.W(LW), .D(LAT-3)) u_y4o (.clk(clk), .rst(rst), .din(y4),  .dout(y4_o));
    lift_delay #(.W(LW), .D(LAT-4)) u_y2o (.clk(clk), .rst(rst), .din(v_n), .dout(y2_o));
    lift_delay #(.W(LW), .D(LAT-6)) u_y6o (.clk(clk), .rst(rst), .din(w_n), .dout(y6_o));

    // ---------------- odd half ----------------
    logic signed [LW-1:0] pm2, b2_d, m2, um2, b1_d, m1, pm3, m2_d, n_s;
    logic signed [LW-1:0] b0_d, b3_d, m1_d, f0, f1, f2, f3;
    logic signed [LW-1:0] pm4, pm5, f0_d, f1_d, g_n, y5, um3, f3_d, h_n;
    logic signed [LW-1:0] y1_o, y5_o, y3_o;

    lift_cmul  #(.W(LW), .COEF(P2), .CWL(CWL)) u_pm2 (.clk(clk), .rst(rst), .din(b_s[1]), .dout(pm2));
    lift_delay #(.W(LW), .D(1)) u_b2d (.clk(clk), .rst(rst), .din(b_s[2]), .dout(b2_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_m2 (.clk(clk), .rst(rst), .a(b2_d), .b(pm2), .dout(m2));

    lift_cmul  #(.W(LW), .COEF(U2), .CWL(CWL)) u_um2 (.clk(clk), .rst(rst), .din(m2), .dout(um2));
    lift_delay #(.W(LW), .D(3)) u_b1d (.clk(clk), .rst(rst), .din(b_s[1]), .dout(b1_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_m1 (.clk(clk), .rst(rst), .a(b1_d), .b(um2), .dout(m1));

    lift_cmul  #(.W(LW), .COEF(P3), .CWL(CWL)) u_pm3 (.clk(clk), .rst(rst), .din(m1), .dout(pm3));
    lift_delay #(.W(LW), .D(3)) u_m2d (.clk(clk), .rst(rst), .din(m2), .dout(m2_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_n (.clk(clk), .rst(rst), .a(m2_d), .b(pm3), .dout(n_s));

    lift_delay #(.W(LW), .D(6)) u_b0d (.clk(clk), .rst(rst), .din(b_s[0]), .dout(b0_d));
    lift_delay #(.W(LW), .D(6)) u_b3d (.clk(clk), .rst(rst), .din(b_s[3]), .dout(b3_d));
    lift_delay #(.W(LW), .D(2)) u_m1d (.clk(clk), .rst(rst), .din(m1),     .dout(m1_d));

    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(ODD_DROP)) u_f0 (.clk(clk), .rst(rst), .a(b0_d), .b(n_s),  .dout(f0));
    lift_addreg #(.W(LW), .SUB(1'b1), .DROP(ODD_DROP)) u_f1 (.clk(clk), .rst(rst), .a(b0_d), .b(n_s),  .dout(f1));
    lift_addreg #(.W(LW), .SUB(1'b1), .DROP(ODD_DROP)) u_f2 (.clk(clk), .rst(rst), .a(b3_d), .b(m1_d), .dout(f2));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(ODD_DROP)) u_f3 (.clk(clk), .rst(rst), .a(b3_d), .b(m1_d), .dout(f3));

    lift_cmul  #(.W(LW), .COEF(P4), .CWL(CWL)) u_pm4 (.clk(clk), .rst(rst), .din(f3), .dout(pm4));
    lift_cmul  #(.W(LW), .COEF(P5), .CWL(CWL)) u_pm5 (.clk(clk), .rst(rst), .din(f2), .dout(pm5));
    lift_delay #(.W(LW), .D(1)) u_f0d (.clk(clk), .rst(rst), .din(f0), .dout(f0_d));
    lift_delay #(.W(LW), .D(1)) u_f1d (.clk(clk), .rst(rst), .din(f1), .dout(f1_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_g  (.clk(clk), .rst(rst), .a(f0_d), .b(pm4), .dout(g_n));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_y5 (.clk(clk), .rst(rst), .a(f1_d), .b(pm5), .dout(y5));

    lift_cmul  #(.W(LW), .COEF(U3), .CWL(CWL)) u_um3 (.clk(clk), .rst(rst), .din(g_n), .dout(um3));
    lift_delay #(.W(LW), .D(3)) u_f3d (.clk(clk), .rst(rst), .din(f3), .dout(f3_d));
    lift_addreg #(.W(LW), .SUB(1'b0), .DROP(0)) u_h (.clk(clk), .rst(rst), .a(f3_d), .b(um3), .dout(h_n));

    lift_delay #(.W(LW), .D(LAT-10)) u_y1o (.clk(clk), .rst(rst), .din(g_n), .dout(y1_o));
    lift_delay #(.W(LW), .D(LAT-10)) u_y5o (.clk(clk), .rst(rst), .din(y5),  .dout(y5_o));
    lift_delay #(.W(LW), .D(LAT-8))  u_y3o (.clk(clk), .rst(rst), .din(f2),  .dout(y3_o));

    // ---------------- valid and output ----------------
    lift_delay #(.W(1), .D(LAT)) u_vld (.clk(clk), .rst(rst), .din(in_valid), .dout(out_valid));

    assign out_coef[0] = y0_o;
    assign out_coef[1] = y1_o;
    assign out_coef[2] = y2_o;
    assign out_coef[3] = y3_o;
    assign out_coef[4] = y4_o;
    assign out_coef[5] = y5_o;
    assign out_coef[6] = y6_o;
    assign out_coef[7] = h_n;

    // Edges seen since reset, saturating, to keep the latency check inside history
    logic [4:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                          since_rst <= '0;
        else if (since_rst < 5'(LAT))     since_rst <= since_rst + 5'd1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 5'(LAT)) |-> (out_valid == $past(in_valid, 12)));

    if (ODD_DROP > 0) begin : g_trunc_chk
        assert_trunc_lsb_R6: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (y3_o[ODD_DROP-1:0] == '0));
    end

endmodule

// File: tb/lift_dct8_bench.sv
module lift_dct8_bench;

    localparam int IN_W = 9;
    localparam int OW   = 13;
    localparam int LAT  = 12;
    localparam int C_P1 = -171, C_U1 = 237, C_P2 = -106, C_U2 = 181;
    localparam int C_P3 = -106, C_P4 = -25, C_U3 = 50,   C_P5 = -78;
    localparam int DROP_T = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic in_valid;
    logic signed [7:0][IN_W-1:0] in_samp;
    logic out_valid, out_valid_t;
    logic signed [7:0][OW-1:0] out_coef, out_coef_t;

    lift_dct8 u_lift_dct8 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samp(in_samp),
        .out_valid(out_valid), .out_coef(out_coef));

    lift_dct8 #(.ODD_DROP(DROP_T)) u_lift_dct8_trunc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samp(in_samp),
        .out_valid(out_valid_t), .out_coef(out_coef_t));

    typedef struct {
        int  due;
        int  ex [8];
        int  et [8];
        real fl [8];
        int  xi [8];
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int mq(input int v, input int c);
        return (v * c) >>> 8;
    endfunction

    function automatic int tr(input int v, input int d);
        return (v >>> d) <<< d;
    endfunction

    function automatic void ref_model(input int x[8], input int d, output int y[8]);
        int a[4], b[4];
        int c0, c1, c2, c3, v, m2, m1, n, f0, f1, f2, f3, g;
        for (int k = 0; k < 4; k++) begin
            a[k] = x[k] + x[7-k];
            b[k] = x[k] - x[7-k];
        end
        c0 = a[0] + a[3]; c1 = a[1] + a[2]; c2 = a[1] - a[2]; c3 = a[0] - a[3];
        y[0] = c0 + c1;
        y[4] = c0 - c1;
        v = c3 + mq(c2, C_P1);
        y[2] = v;
        y[6] = c2 + mq(v, C_U1);
        m2 = b[2] + mq(b[1], C_P2);
        m1 = b[1] + mq(m2, C_U2);
        n  = m2 + mq(m1, C_P3);
        f0 = tr(b[0] + n, d);  f1 = tr(b[0] - n, d);
        f2 = tr(b[3] - m1, d); f3 = tr(b[3] + m1, d);
        g = f0 + mq(f3, C_P4);
        y[1] = g;
        y[5] = f1 + mq(f2, C_P5);
        y[7] = f3 + mq(g, C_U3);
        y[3] = f2;
    endfunction

    function automatic void flt_model(input int x[8], output real y[8]);
        real a[4], b[4];
        real c0, c1, c2, c3, v, m2, m1, n, f0, f1, f2, f3, g;
        for (int k = 0; k < 4; k++) begin
            a[k] = real'(x[k] + x[7-k]);
            b[k] = real'(x[k] - x[7-k]);
        end
        c0 = a[0] + a[3]; c1 = a[1] + a[2]; c2 = a[1] - a[2]; c3 = a[0] - a[3];
        y[0] = c0 + c1;
        y[4] = c0 - c1;
        v = c3 + c2 * C_P1 / 256.0;
        y[2] = v;
        y[6] = c2 + v * C_U1 / 256.0;
        m2 = b[2] + b[1] * C_P2 / 256.0;
        m1 = b[1] + m2 * C_U2 / 256.0;
        n  = m2 + m1 * C_P3 / 256.0;
        f0 = b[0] + n; f1 = b[0] - n; f2 = b[3] - m1; f3 = b[3] + m1;
        g = f0 + f3 * C_P4 / 256.0;
        y[1] = g;
        y[5] = f1 + f2 * C_P5 / 256.0;
        y[7] = f3 + g * C_U3 / 256.0;
        y[3] = f2;
    endfunction

    function automatic int lane(input logic signed [7:0][OW-1:0] v, input int k);
        return int'(signed'(v[k]));
    endfunction

    task automatic drive(input bit v, input int x[8]);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        for (int k = 0; k < 8; k++) in_samp[k] = x[k][IN_W-1:0];
        if (v) begin
            e.due = cyc + LAT;
            e.xi = x;
            ref_model(x, 0, e.ex);
            ref_model(x, DROP_T, e.et);
            flt_model(x, e.fl);
            q.push_back(e);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            bit ev;
            ev = (q.size() > 0) && (q[0].due == cyc);
            chk(out_valid == ev, "R2 valid timing", int'(out_valid), int'(ev));
            chk(out_valid_t == ev, "R2 valid timing (trunc)", int'(out_valid_t), int'(ev));
            if (ev) begin
                exp_t e;
                int s, s4, err;
                e = q.pop_front();
                for (int k = 0; k < 8; k++) begin
                    chk(lane(out_coef, k) == e.ex[k], $sformatf("R1 lane %0d", k),
                        lane(out_coef, k), e.ex[k]);
                    chk(lane(out_coef_t, k) == e.et[k], $sformatf("R6 lane %0d", k),
                        lane(out_coef_t, k), e.et[k]);
                    err = int'($rtoi((real'(lane(out_coef, k)) - e.fl[k]) * 100.0));
                    if (err < 0) err = -err;
                    chk(err <= 600, $sformatf("R7 lane %0d error x100", k), err, 600);
                end
                s = 0;
                for (int k = 0; k < 8; k++) s += e.xi[k];
                s4 = (e.xi[0] + e.xi[3] + e.xi[4] + e.xi[7]) - (e.xi[1] + e.xi[2] + e.xi[5] + e.xi[6]);
                chk(lane(out_coef, 0) == s, "R5 DC sum", lane(out_coef, 0), s);
                chk(lane(out_coef, 4) == s4, "R5 lane 4 sum", lane(out_coef, 4), s4);
                chk((lane(out_coef_t, 3) & 3) == 0, "R6 lane 3 low bits", lane(out_coef_t, 3) & 3, 0);
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        int x[8];
        void'($urandom(32'd4242));
        rst = 1'b1;
        in_valid = 1'b0;
        in_samp = '0;
        repeat (3) @(negedge clk);
        // R8: state during reset
        chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        chk(out_coef == '0, "R8 out_coef in reset", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
        for (int k = 0; k < 8; k++)
            chk(lane(out_coef, k) == 0, "R8 lane zero after reset", lane(out_coef, k), 0);
        mon_on = 1'b1;

        // Directed: full scale positive and negative (R3), zero, alternating
        for (int k = 0; k < 8; k++) x[k] = 255;
        drive(1'b1, x);
        for (int k = 0; k < 8; k++) x[k] = -255;
        drive(1'b1, x);
        for (int k = 0; k < 8; k++) x[k] = 0;
        drive(1'b1, x);
        for (int k = 0; k < 8; k++) x[k] = (k % 2 == 0) ? 255 : -255;
        drive(1'b1, x);
        for (int k = 0; k < 8; k++) x[k] = (k < 4) ? 255 : -255;
        drive(1'b1, x);
        for (int k = 0; k < 8; k++) x[k] = ((k == 1) || (k == 2) || (k == 5) || (k == 6)) ? -255 : 255;
        drive(1'b1, x);
        // Impulses in each lane, both signs
        for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 8; k++) x[k] = (k == j) ? 255 : 0;
            drive(1'b1, x);
            for (int k = 0; k < 8; k++) x[k] = (k == j) ? -1 : 0;
            drive(1'b1, x);
        end
        // Gap of invalid cycles carrying nonzero data (R2)
        for (int k = 0; k < 8; k++) x[k] = 100 - 30 * k;
        repeat (3) drive(1'b0, x);
        drive(1'b1, x);
        // Random with bubbles
        for (int i = 0; i < 600; i++) begin
            for (int k = 0; k < 8; k++) x[k] = int'($urandom_range(0, 510)) - 255;
            drive(($urandom_range(0, 3) != 0), x);
        end
        for (int k = 0; k < 8; k++) x[k] = 0;
        repeat (LAT + 4) drive(1'b0, x);
        chk(q.size() == 0, "R2 all vectors delivered", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual 0 expected 1");
            summary();
            $finish;
        end
    end

endmodule